// File: doc/BRIEF.md
# Serial Peripheral Transfer Master

This block is a memory-mapped serial master. Software programs a byte count, a serial rate, one of three select lines, a lane width (one data line or four) and a direction, then sets the enable bit. The block moves exactly that many bytes in the chosen direction. All data passes through a single 32-bit data window, one word of up to four bytes at a time. Within a word, the lowest byte goes first.

Flow control at the data window is a plain busy flag. In write direction, the flag rises when software stores a word. It falls once every byte of that word has been shifted out. In read direction, the flag stays high while the block is gathering a word. It falls when the word is ready. Reading the data window hands the word to software and lets the block gather the next one. A data write while busy is high is dropped. The serial engine never runs ahead of software, so no data is lost when software is slow; the serial clock simply pauses low between words.

When the count reaches zero, the enable bit clears and a transfer-end event is latched. The event can be masked and is acknowledged by writing a one. The select line stays asserted across transfers until software releases it. This lets a command phase and a data phase share one selection. The serial timing is mode 0: the clock idles low, the device samples on the rising edge, and outputs change only while the clock is low.

Top module: `spi_xfer_master`

## Requirements
- R1: After reset all select outputs are high, the serial clock is low, irq is low, and both the control register (offset 0x00) and the status register (offset 0x10) read 0.
- R2: Control bits 2:0 pick the serial rate. Code c (0 to 5) gives a serial clock period of 2*HALF_MIN*2^(5-c) system clocks, so each code doubles the rate of the one before. Codes 6 and 7 behave as code 5.
- R3: Setting enable (control bit 15) while no line is selected drives spi_cs_n[n] low, where n is control bits 7:6. At most one select output is low at any time, and it stays low after the transfer ends.
- R4: Writing the value 0 to offset 0x04 while no transfer runs drives all select outputs high. Writing a nonzero value there has no effect.
- R5: With control bit 13 = 1 (write) and bit 12 = 0 (single lane), each byte takes 8 serial clock periods on spi_io_out[0], MSB first. Bytes come from the word written at offset 0x0C, bits 7:0 first, then 15:8, 23:16 and 31:24.
- R6: With control bit 12 = 1 (quad lane) in write direction, each byte takes 2 serial clock periods on spi_io_out[3:0], high nibble first.
- R7: With control bit 13 = 0 (read), single lane samples spi_io_in[1] and quad lane samples spi_io_in[3:0] on each rising serial clock edge. Bytes are packed into the word at offset 0x0C, first byte in bits 7:0. Byte positions past the end of the count read 0. Reading offset 0x0C releases the word.
- R8: Status bit 0 at offset 0x10 is busy. In write direction it is high from a data write until that word is consumed. In read direction it is high while enabled and no word is waiting. A data write while busy is ignored.
- R9: Offset 0x08 bits 20:0 hold the byte count. The transfer ends after that many bytes, and enable then reads back 0. A count of 0 ends the transfer with no serial clock edge.
- R10: Interrupt status bit 0 at offset 0x1C is set when enable clears and is cleared by writing 1 to it. irq equals that bit AND NOT mask bit 0 at offset 0x18.
- R11: The serial clock is low whenever no line is selected, and spi_io_out does not change while the serial clock is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the data word) |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| irq | output | 1 | Unmasked transfer-end interrupt |
| spi_sclk | output | 1 | Serial clock |
| spi_cs_n | output | NUM_CS | Active-low select lines |
| spi_io_out | output | 4 | Serial data out; lane 0 is the single-lane output |
| spi_io_oe | output | 4 | Output enables for each data lane |
| spi_io_in | input | 4 | Serial data in; lane 1 is the single-lane input |

## Verification
The bench targets the edges of the word window. A five-byte write crosses a word boundary. A six-byte read leaves a partial second word. A design that reset its byte index wrongly would repeat or skip bytes, and one that did not clear the word would return stale upper bytes. A data write issued while busy must not be sent; a design that accepted it would emit bytes the scoreboard never queued. Other tests cover a zero count that must end with no serial clock edge, a masked interrupt that must latch without raising irq, and a nonzero write to the select register that must leave the device selected. Each rate code is also timed; a design with an off-by-one prescaler would show a period that differs from the power-of-two value.

// File: rtl/spi_xfer_pkg.sv
package spi_xfer_pkg;
  localparam logic [4:0] OFS_CTRL  = 5'h00;
  localparam logic [4:0] OFS_CSEL  = 5'h04;
  localparam logic [4:0] OFS_LEN   = 5'h08;
  localparam logic [4:0] OFS_DATA  = 5'h0C;
  localparam logic [4:0] OFS_STAT  = 5'h10;
  localparam logic [4:0] OFS_IMASK = 5'h18;
  localparam logic [4:0] OFS_ISTAT = 5'h1C;

  localparam int CTL_EN_BIT   = 15;
  localparam int CTL_DIR_BIT  = 13;
  localparam int CTL_QUAD_BIT = 12;
  localparam int NUM_RATES    = 6;

  typedef struct packed {
    logic [2:0] rate;
    logic [1:0] line;
    logic       quad;
    logic       wr_dir;
  } xfer_ctl_t;
endpackage

// File: rtl/spi_clk_div.sv
module spi_clk_div #(
  parameter int HALF_MIN = 2,
  parameter int NCODES   = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [2:0] rate,
  output logic       tick
);
  localparam int MAXC = NCODES - 1;
  localparam int CW   = $clog2(HALF_MIN << MAXC) + 1;

  logic [CW-1:0] cnt;
  logic [CW-1:0] limit;
  int            code_i;

  always_comb begin
    code_i = (int'(rate) > MAXC) ? MAXC : int'(rate);
    limit  = CW'((HALF_MIN << (MAXC - code_i)) - 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!run || cnt == limit) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign tick = run && (cnt == limit);
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine #(
  parameter int BYTE_W = 8,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              quad,
  input  logic [BYTE_W-1:0] tx_byte,
  input  logic              tick,
  input  logic [LANES-1:0]  io_in,
  output logic              busy,
  output logic              done,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              sclk,
  output logic [LANES-1:0]  dout
);
  localparam int CNT_W     = $clog2(BYTE_W);
  localparam int SER_LAST  = BYTE_W - 1;
  localparam int QUAD_LAST = BYTE_W / LANES - 1;

  logic [BYTE_W-1:0] sh;
  logic [BYTE_W-1:0] rx;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  last;
  logic              hi;
  logic              quad_q;

  assign last = quad_q ? CNT_W'(QUAD_LAST) : CNT_W'(SER_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh     <= '0;
      rx     <= '0;
      cnt    <= '0;
      hi     <= 1'b0;
      busy   <= 1'b0;
      done   <= 1'b0;
      quad_q <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        sh     <= tx_byte;
        rx     <= '0;
        cnt    <= '0;
        hi     <= 1'b0;
        busy   <= 1'b1;
        quad_q <= quad;
      end else if (busy && tick) begin
        if (!hi) begin
          hi <= 1'b1;
          if (quad_q) rx <= {rx[BYTE_W-LANES-1:0], io_in};
          else        rx <= {rx[BYTE_W-2:0], io_in[1]};
        end else begin
          hi <= 1'b0;
          if (quad_q) sh <= {sh[BYTE_W-LANES-1:0], {LANES{1'b0}}};
          else        sh <= {sh[BYTE_W-2:0], 1'b0};
          if (cnt == last) begin
            busy <= 1'b0;
            done <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      end
    end
  end

  assign sclk    = hi;
  assign rx_byte = rx;
  assign dout    = quad_q ? sh[BYTE_W-1 -: LANES] : {{(LANES-1){1'b0}}, sh[BYTE_W-1]};
endmodule

// File: rtl/spi_xfer_master.sv
module spi_xfer_master
  import spi_xfer_pkg::*;
#(
  parameter int HALF_MIN = 2,
  parameter int LEN_W    = 21,
  parameter int NUM_CS   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [4:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq,
  output logic              spi_sclk,
  output logic [NUM_CS-1:0] spi_cs_n,
  output logic [3:0]        spi_io_out,
  output logic [3:0]        spi_io_oe,
  input  logic [3:0]        spi_io_in
);
  localparam int         IDX_W   = 2;
  localparam logic [1:0] IDX_MAX = 2'd3;

  xfer_ctl_t         ctl;
  logic              en;
  logic [LEN_W-1:0]  len_reg;
  logic [LEN_W-1:0]  rem;
  logic [31:0]       word;
  logic [IDX_W-1:0]  idx;
  logic              have_word;
  logic              cs_act;
  logic [1:0]        cs_line;
  logic              imask;
  logic              istat;

  logic              eng_busy, eng_done, eng_start, tick;
  logic [7:0]        eng_rx, tx_byte;
  logic [3:0]        eng_dout;
  logic              fifo_busy, finish;
  logic              wr_ctl, wr_len, wr_csel, wr_imask, wr_istat, wr_data, rd_data;
  logic [31:0]       ctrl_rd;

  // register access decode
  assign wr_ctl   = reg_wr && reg_addr == OFS_CTRL && !en;
  assign wr_len   = reg_wr && reg_addr == OFS_LEN  && !en;
  assign wr_csel  = reg_wr && reg_addr == OFS_CSEL && !en;
  assign wr_imask = reg_wr && reg_addr == OFS_IMASK;
  assign wr_istat = reg_wr && reg_addr == OFS_ISTAT;
  assign wr_data  = reg_wr && reg_addr == OFS_DATA && en && ctl.wr_dir && !have_word;
  assign rd_data  = reg_rd && reg_addr == OFS_DATA && !ctl.wr_dir && have_word;

  assign fifo_busy = ctl.wr_dir ? have_word : (en && !have_word);
  assign finish    = en && rem == '0 && !eng_busy && !eng_done;
  assign eng_start = en && !eng_busy && !eng_done && rem != '0 &&
                     (ctl.wr_dir ? have_word : !have_word);
  assign tx_byte   = ctl.wr_dir ? word[{idx, 3'b000} +: 8] : 8'hFF;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl       <= '0;
      en        <= 1'b0;
      len_reg   <= '0;
      rem       <= '0;
      word      <= '0;
      idx       <= '0;
      have_word <= 1'b0;
      cs_act    <= 1'b0;
      cs_line   <= '0;
      imask     <= 1'b0;
      istat     <= 1'b0;
    end else begin
      if (wr_ctl) begin
        ctl.rate   <= reg_wdata[2:0];
        ctl.line   <= reg_wdata[7:6];
        ctl.quad   <= reg_wdata[CTL_QUAD_BIT];
        ctl.wr_dir <= reg_wdata[CTL_DIR_BIT];
        if (reg_wdata[CTL_EN_BIT]) begin
          en        <= 1'b1;
          rem       <= len_reg;
          have_word <= 1'b0;
          idx       <= '0;
          word      <= '0;
          if (!cs_act) begin
            cs_act  <= 1'b1;
            cs_line <= reg_wdata[7:6];
          end
        end
      end
      if (wr_len) len_reg <= reg_wdata[LEN_W-1:0];
      if (wr_csel && reg_wdata == '0) cs_act <= 1'b0;
      if (wr_imask) imask <= reg_wdata[0];
      if (wr_data) begin
        word      <= reg_wdata;
        have_word <= 1'b1;
        idx       <= '0;
      end
      if (rd_data) begin
        word      <= '0;
        have_word <= 1'b0;
        idx       <= '0;
      end
      if (eng_done) begin
        rem <= rem - 1'b1;
        idx <= idx + 1'b1;
        if (!ctl.wr_dir) word[{idx, 3'b000} +: 8] <= eng_rx;
        if (idx == IDX_MAX || rem == LEN_W'(1)) have_word <= !ctl.wr_dir;
      end
      if (finish) begin
        en <= 1'b0;
        if (ctl.wr_dir) have_word <= 1'b0;
      end
      istat <= (istat & ~(wr_istat & reg_wdata[0])) | finish;
    end
  end

  spi_clk_div #(.HALF_MIN(HALF_MIN), .NCODES(NUM_RATES)) u_div (
    .clk(clk), .rst_n(rst_n), .run(eng_busy), .rate(ctl.rate), .tick(tick)
  );

  spi_shift_engine #(.BYTE_W(8), .LANES(4)) u_eng (
    .clk(clk), .rst_n(rst_n), .start(eng_start), .quad(ctl.quad),
    .tx_byte(tx_byte), .tick(tick), .io_in(spi_io_in), .busy(eng_busy),
    .done(eng_done), .rx_byte(eng_rx), .sclk(spi_sclk), .dout(eng_dout)
  );

  for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
    assign spi_cs_n[i] = !(cs_act && cs_line == 2'(i));
  end

  assign spi_io_out = eng_dout;
  always_comb begin
    if (!en)            spi_io_oe = 4'h0;
    else if (ctl.quad)  spi_io_oe = ctl.wr_dir ? 4'hF : 4'h0;
    else                spi_io_oe = 4'h1;
  end

  assign irq     = istat & ~imask;
  assign ctrl_rd = {16'b0, en, 1'b0, ctl.wr_dir, ctl.quad, 4'b0, ctl.line, 3'b0, ctl.rate};

  always_comb begin
    case (reg_addr)
      OFS_CTRL:  reg_rdata = ctrl_rd;
      OFS_CSEL:  reg_rdata = {31'b0, cs_act};
      OFS_LEN:   reg_rdata = {{(32-LEN_W){1'b0}}, len_reg};
      OFS_DATA:  reg_rdata = word;
      OFS_STAT:  reg_rdata = {31'b0, fifo_busy};
      OFS_IMASK: reg_rdata = {31'b0, imask};
      OFS_ISTAT: reg_rdata = {31'b0, istat};
      default:   reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/spi_xfer_chk.sv
module spi_xfer_chk #(
  parameter int NUM_CS = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en,
  input logic              busy,
  input logic              eng_busy,
  input logic              te,
  input logic              sclk,
  input logic [NUM_CS-1:0] cs_n,
  input logic [3:0]        io_out
);
  // R8
  busy_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> en);

  // R3
  one_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));

  // R11
  sclk_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (&cs_n) |-> !sclk);

  // R11
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(io_out));

  // R10
  end_latched_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en) |-> te);

  // R9
  shift_in_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_busy |-> en);
endmodule

bind spi_xfer_master spi_xfer_chk #(.NUM_CS(NUM_CS)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .busy(fifo_busy), .eng_busy(eng_busy),
  .te(istat), .sclk(spi_sclk), .cs_n(spi_cs_n), .io_out(spi_io_out)
);

// File: tb/sim_spi_xfer_master.sv
module sim_spi_xfer_master;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int CLK_PERIOD = 10;
  localparam int HALF_MIN   = 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq, spi_sclk;
  logic [2:0]  spi_cs_n;
  logic [3:0]  spi_io_out, spi_io_oe, spi_io_in;

  int nerr = 0, nchk = 0;
  int cyc = 0, last_rise = 0, gap = 0, nrise = 0, viol = 0;
  logic [7:0] exp_q[$];
  bit   mon_on = 0, mon_quad = 0;
  logic [7:0] mon_sh = '0;
  int   mon_bits = 0;
  logic [63:0] dev_sr = '0;
  bit   dev_quad = 0;
  logic prev_sclk = 1'b0;
  logic [3:0] prev_out = '0;
  logic [31:0] rv;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc++;

  spi_xfer_master #(.HALF_MIN(HALF_MIN)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
    .spi_io_out(spi_io_out), .spi_io_oe(spi_io_oe), .spi_io_in(spi_io_in)
  );

  assign spi_io_in = dev_quad ? dev_sr[63:60] : {2'b00, dev_sr[63], 1'b0};

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // device model: next bit appears on each falling edge
  always @(negedge spi_sclk) dev_sr = dev_quad ? (dev_sr << 4) : (dev_sr << 1);

  // monitor: rebuild bytes on rising edges, compare with scoreboard
  always @(posedge spi_sclk) begin
    gap = cyc - last_rise;
    last_rise = cyc;
    nrise++;
    if (mon_on) begin
      if (mon_quad) begin mon_sh = {mon_sh[3:0], spi_io_out}; mon_bits += 4; end
      else          begin mon_sh = {mon_sh[6:0], spi_io_out[0]}; mon_bits += 1; end
      if (mon_bits == 8) begin
        mon_bits = 0;
        if (exp_q.size() == 0) chk(0, "R5/R6 unexpected byte", {24'b0, mon_sh}, 32'h0);
        else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          chk(mon_sh == e, mon_quad ? "R6 quad byte" : "R5 serial byte", {24'b0, mon_sh}, {24'b0, e});
        end
      end
    end
  end

  // R11: outputs must not move while the clock is high
  always @(negedge clk) begin
    if (spi_sclk && prev_sclk && spi_io_out != prev_out) viol++;
    prev_sclk = spi_sclk;
    prev_out  = spi_io_out;
  end

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic wait_not_busy();
    logic [31:0] s;
    for (int i = 0; i < 5000; i++) begin
      rd(5'h10, s);
      if (!s[0]) return;
    end
  endtask

  task automatic wait_done();
    logic [31:0] s;
    for (int i = 0; i < 5000; i++) begin
      rd(5'h00, s);
      if (!s[15]) return;
    end
  endtask

  task automatic do_write(input logic [1:0] line, input bit quad, input logic [2:0] rate,
                          input logic [7:0] data[$], input bit poke);
    int n;
    logic [31:0] w, s;
    n = data.size();
    foreach (data[i]) exp_q.push_back(data[i]);
    mon_quad = quad; mon_bits = 0; mon_on = 1;
    wr(5'h08, n);
    wr(5'h00, (32'h1 << 15) | (32'h1 << 13) | (32'(quad) << 12) | (32'(line) << 6) | 32'(rate));
    for (int wi = 0; wi < (n + 3) / 4; wi++) begin
      wait_not_busy();
      w = '0;
      for (int k = 0; k < 4; k++) if (wi * 4 + k < n) w[k*8 +: 8] = data[wi*4 + k];
      wr(5'h0C, w);
      if (poke) begin
        rd(5'h10, s);
        chk(s[0] == 1'b1, "R8 busy after data write", s, 32'h1);
        wr(5'h0C, 32'h9966_3377); // must be dropped
      end
    end
    wait_done();
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R5/R6 all bytes sent", exp_q.size(), 0);
    exp_q.delete();
    mon_on = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    int r0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(spi_cs_n == 3'b111, "R1 selects high", spi_cs_n, 3'b111);
    chk(spi_sclk == 1'b0, "R1 sclk low", spi_sclk, 0);
    chk(irq == 1'b0, "R1 irq low", irq, 0);
    rd(5'h10, rv); chk(rv == 0, "R1 status", rv, 0);
    rd(5'h00, rv); chk(rv == 0, "R1 control", rv, 0);

    // R5 single-lane write across a word boundary on line 1
    do_write(2'd1, 1'b0, 3'd5, '{8'h11, 8'h82, 8'hC3, 8'hF4, 8'h5A}, 1'b0);
    rd(5'h00, rv); chk(rv[15] == 1'b0, "R9 enable cleared", rv, 0);
    chk(spi_cs_n == 3'b101, "R3 line 1 held", spi_cs_n, 3'b101);
    rd(5'h1C, rv); chk(rv == 1, "R10 end latched", rv, 1);
    chk(irq == 1'b1, "R10 irq raised", irq, 1);
    wr(5'h1C, 1); @(negedge clk);
    rd(5'h1C, rv); chk(rv == 0, "R10 acknowledge", rv, 0);
    chk(irq == 1'b0, "R10 irq dropped", irq, 0);

    // R4 release rules
    wr(5'h04, 1); @(negedge clk);
    chk(spi_cs_n == 3'b101, "R4 nonzero ignored", spi_cs_n, 3'b101);
    wr(5'h04, 0); @(negedge clk);
    chk(spi_cs_n == 3'b111, "R4 release", spi_cs_n, 3'b111);

    // R6 quad write with masked interrupt and a dropped busy write (R8)
    wr(5'h18, 1);
    do_write(2'd2, 1'b1, 3'd5, '{8'h3C, 8'hA7, 8'h5E}, 1'b1);
    chk(spi_cs_n == 3'b011, "R3 line 2 held", spi_cs_n, 3'b011);
    rd(5'h1C, rv); chk(rv == 1, "R10 masked still latched", rv, 1);
    chk(irq == 1'b0, "R10 masked irq", irq, 0);
    wr(5'h1C, 1); wr(5'h18, 0); wr(5'h04, 0);

    // R7 single-lane read of six bytes on line 0
    dev_quad = 0; dev_sr = 64'hDEADBEEF_CAFE0000;
    wr(5'h08, 6);
    wr(5'h00, (32'h1 << 15) | 32'd5);
    @(negedge clk);
    chk(spi_cs_n == 3'b110, "R3 line 0", spi_cs_n, 3'b110);
    wait_not_busy();
    rd(5'h0C, rv); chk(rv == 32'hEFBEADDE, "R7 read word 0", rv, 32'hEFBEADDE);
    wait_not_busy();
    rd(5'h0C, rv); chk(rv == 32'h0000FECA, "R7 read partial word", rv, 32'h0000FECA);
    wait_done();
    wr(5'h1C, 1);

    // R7 quad read of two bytes
    dev_quad = 1; dev_sr = 64'h5C3A_0000_0000_0000;
    wr(5'h08, 2);
    wr(5'h00, (32'h1 << 15) | (32'h1 << 12) | 32'd5);
    wait_not_busy();
    rd(5'h0C, rv); chk(rv == 32'h00003A5C, "R7 quad read", rv, 32'h00003A5C);
    wait_done();
    wr(5'h1C, 1); wr(5'h04, 0);
    dev_quad = 0;

    // R9 zero count: no clock edge
    r0 = nrise;
    wr(5'h08, 0);
    wr(5'h00, (32'h1 << 15) | (32'h1 << 13) | 32'd5);
    repeat (6) @(negedge clk);
    rd(5'h00, rv); chk(rv[15] == 1'b0, "R9 zero count ends", rv, 0);
    rd(5'h1C, rv); chk(rv == 1, "R9 zero count end event", rv, 1);
    chk(nrise == r0, "R9 zero count no edges", nrise, r0);
    wr(5'h1C, 1); wr(5'h04, 0);

    // R2 every rate code
    for (int c = 0; c < 6; c++) begin
      do_write(2'd0, 1'b0, 3'(c), '{8'hA5}, 1'b0);
      chk(gap == 2 * HALF_MIN * (1 << (5 - c)), "R2 clock period", gap, 2 * HALF_MIN * (1 << (5 - c)));
      wr(5'h1C, 1);
    end
    wr(5'h04, 0);

    chk(viol == 0, "R11 data stable while clock high", viol, 0);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule